// File: doc/BRIEF.md
# Signed Karatsuba Fixed-Point Multiplier

This block multiplies two signed two's-complement fixed-point operands of 16 bits, each carrying 8 fraction bits. It returns the exact signed 32-bit product, which then carries 16 fraction bits. Only the interpretation changes with the binary point: the output word is the raw integer product of the two input words.

The product is built with a one-level Karatsuba split. Each operand becomes a signed upper half and an unsigned lower half. Three narrower products replace the four partial products of a schoolbook multiplier: upper times upper, lower times lower, and the product of the two half-sums. The cross term is that third product minus the other two. The three terms are then weighted and summed.

Keeping the upper half signed and the lower half unsigned makes every sign combination exact. The half-sums are widened by two bits so that the middle product cannot wrap. One output register stage is present by default. A parameter can remove it to give a purely combinational path.

Top module: `karatsuba_fxp_mul`

## Requirements
- R1: Once the output register has loaded, `product` equals the full signed product of `opA` and `opB` as they were at the previous rising clock edge, for every pair of 16-bit values.
- R2: With the default single register stage, a change on `opA` or `opB` does not reach `product` before the next rising edge, and `product` stays constant while the inputs stay constant.
- R3: `product` is zero while `rstN` is low. It stays zero through the first rising edge after `rstN` goes high. The first operands are loaded at the second rising edge after release.
- R4: `opA` = 0xA7C0 (-88.25) and `opB` = 0x1440 (20.25) give `product` = 0xF904F000 (-1787.0625 with 16 fraction bits).
- R5: The extreme operand pairs give these results: 0x8000 x 0x8000 = 0x40000000, 0x7FFF x 0x7FFF = 0x3FFF0001, 0x8000 x 0x7FFF = 0xC0008000, and 0xFFFF x 0xFFFF = 0x00000001. Any operand of 0x0000 gives 0.
- R6: When both operands are non-zero, bit 31 of `product` equals the XOR of bit 15 of `opA` and bit 15 of `opB`.
- R7: `opB` = 0x0100 (the value 1.0) gives `product` equal to `opA` sign-extended to 32 bits and shifted left by 8. This is the same value expressed with 16 fraction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | Multiplicand: signed, 8 fraction bits |
| opB | input | 16 | Multiplier: signed, 8 fraction bits |
| product | output | 32 | Signed product, 16 fraction bits |

## Verification
The checker tests five properties on every clock cycle. It compares `product` with the signed product of the previous cycle's inputs. It checks that the output is zero during and just after reset, and that bit 31 follows the sign rule. It checks scaling by 1.0, and that the output holds while the inputs are held.

Some behaviour only the bench scenarios can show: the exact test vector, and that no input change leaks through before the clock edge. The bench also sweeps every combination of upper bytes with varied lower bytes, which drives the carry and borrow paths of the middle term through all sign combinations.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic loadOut;
  } kmulStrobe_t;
endpackage

// File: rtl/kmul_partial.sv
// Generic partial-product multiplier, signed or unsigned operands
module kmul_partial #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter bit SIGNED_OPS = 1'b1
) (
  input  logic [AW-1:0]    x,
  input  logic [BW-1:0]    y,
  output logic [AW+BW-1:0] p
);
  generate
    if (SIGNED_OPS) begin : g_signed
      assign p = $signed(x) * $signed(y);
    end else begin : g_unsigned
      assign p = x * y;
    end
  endgenerate
endmodule

// File: rtl/kmul_ctrl.sv
// Control: holds off the output load until one full cycle after reset
module kmul_ctrl
  import kmul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output kmulStrobe_t strobe
);
  logic readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign strobe.loadOut = readyQ;
endmodule

// File: rtl/kmul_dp.sv
// Datapath: one-level Karatsuba split, signed upper half, unsigned lower half
module kmul_dp
  import kmul_pkg::*;
#(
  parameter int HALF    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  kmulStrobe_t         strobe,
  input  logic [2*HALF-1:0]   opA,
  input  logic [2*HALF-1:0]   opB,
  output logic [4*HALF-1:0]   product
);
  localparam int OPW = 2 * HALF;   // operand width
  localparam int PW  = 4 * HALF;   // product width
  localparam int SW  = HALF + 2;   // widened half-sum width
  localparam int MW  = 2 * SW;     // middle-term width

  logic [HALF-1:0] aHi, aLo, bHi, bLo;
  assign aHi = opA[OPW-1:HALF];
  assign aLo = opA[HALF-1:0];
  assign bHi = opB[OPW-1:HALF];
  assign bLo = opB[HALF-1:0];

  // Half sums: signed upper half plus zero-extended lower half
  logic [SW-1:0] sumA, sumB;
  assign sumA = {{2{aHi[HALF-1]}}, aHi} + {2'b00, aLo};
  assign sumB = {{2{bHi[HALF-1]}}, bHi} + {2'b00, bLo};

  logic [OPW-1:0] hiProd;   // signed
  logic [OPW-1:0] loProd;   // unsigned
  logic [MW-1:0]  sumProd;  // signed

  kmul_partial #(.AW(HALF), .BW(HALF), .SIGNED_OPS(1'b1)) u_hi (
    .x(aHi), .y(bHi), .p(hiProd)
  );
  kmul_partial #(.AW(HALF), .BW(HALF), .SIGNED_OPS(1'b0)) u_lo (
    .x(aLo), .y(bLo), .p(loProd)
  );
  kmul_partial #(.AW(SW), .BW(SW), .SIGNED_OPS(1'b1)) u_mid (
    .x(sumA), .y(sumB), .p(sumProd)
  );

  // Cross term = sumProd - hiProd - loProd, kept at MW signed bits
  logic [MW-1:0] midTerm;
  assign midTerm = sumProd
                 - {{(MW-OPW){hiProd[OPW-1]}}, hiProd}
                 - {{(MW-OPW){1'b0}}, loProd};

  logic [PW-1:0] hiExt, midExt, loExt, combResult;
  assign hiExt  = {hiProd, {OPW{1'b0}}};
  assign midExt = {{(PW-MW-HALF){midTerm[MW-1]}}, midTerm, {HALF{1'b0}}};
  assign loExt  = {{(PW-OPW){1'b0}}, loProd};
  assign combResult = hiExt + midExt + loExt;

  generate
    if (REG_OUT) begin : g_reg
      logic [PW-1:0] productQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               productQ <= '0;
        else if (strobe.loadOut) productQ <= combResult;
      end
      assign product = productQ;
    end else begin : g_comb
      assign product = combResult;
    end
  endgenerate
endmodule

// File: rtl/karatsuba_fxp_mul.sv
// Top: signed fixed-point Karatsuba multiplier
module karatsuba_fxp_mul
  import kmul_pkg::*;
#(
  parameter int HALF    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2*HALF-1:0] opA,
  input  logic [2*HALF-1:0] opB,
  output logic [4*HALF-1:0] product
);
  kmulStrobe_t strobe;

  kmul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  kmul_dp #(.HALF(HALF), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .product(product)
  );
endmodule

// Checker bound to the top
module kmul_chk #(
  parameter int HALF    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [2*HALF-1:0] opA,
  input logic [2*HALF-1:0] opB,
  input logic [4*HALF-1:0] product
);
  localparam int OPW = 2 * HALF;
  localparam int PW  = 4 * HALF;
  localparam logic [OPW-1:0] ONE = OPW'(1) << HALF;

  logic signed [PW-1:0] refProd;
  logic [PW-1:0] unitRef;
  assign refProd = $signed(opA) * $signed(opB);
  assign unitRef = {{(PW-OPW){opA[OPW-1]}}, opA} << HALF;

  generate
    if (REG_OUT) begin : g_seq
      logic [1:0] edgeCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               edgeCnt <= 2'd0;
        else if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
      end

      // R1: exact product of the previous cycle's operands
      a_r1_exact: assert property (@(posedge clk) disable iff (!rstN)
        (edgeCnt >= 2'd2) |-> (product == $past(refProd)));

      // R3: zero until the second edge after reset release
      a_r3_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
        (edgeCnt < 2'd2) |-> (product == '0));

      // R6: sign rule for non-zero operands
      a_r6_sign: assert property (@(posedge clk) disable iff (!rstN)
        (edgeCnt >= 2'd2 && $past(opA) != '0 && $past(opB) != '0) |->
        (product[PW-1] == ($past(opA[OPW-1]) ^ $past(opB[OPW-1]))));

      // R7: multiplying by 1.0 rescales the multiplicand
      a_r7_unit_scale: assert property (@(posedge clk) disable iff (!rstN)
        (edgeCnt >= 2'd2 && $past(opB) == ONE) |-> (product == $past(unitRef)));

      // R2: output holds while the operands hold
      a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
        (edgeCnt == 2'd3 && $past(opA) == $past(opA, 2) && $past(opB) == $past(opB, 2))
        |-> $stable(product));
    end else begin : g_comb
      always_comb begin
        // R1: combinational variant is exact at all times
        a_r1_comb_exact: assert (product == refProd);
      end
    end
  endgenerate
endmodule

bind karatsuba_fxp_mul kmul_chk #(.HALF(HALF), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .product(product)
);

// File: tb/karatsuba_fxp_mul_tb.sv
`timescale 1ns/1ps
module karatsuba_fxp_mul_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = 16'h0000;
  logic [15:0] opB = 16'h0000;
  logic [31:0] product;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  karatsuba_fxp_mul u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .product(product)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refMul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  // Drive at a falling edge, check at the next falling edge
  task automatic run(input string tag, input logic [15:0] a, input logic [15:0] b);
    opA = a;
    opB = b;
    @(negedge clk);
    chk(tag, product, refMul(a, b));
  endtask

  initial begin
    logic [31:0] seed;
    logic [31:0] prevExp;
    logic [15:0] corners [8];
    corners[0] = 16'h8000; corners[1] = 16'h7FFF; corners[2] = 16'h0000;
    corners[3] = 16'hFFFF; corners[4] = 16'h0001; corners[5] = 16'h00FF;
    corners[6] = 16'hFF00; corners[7] = 16'h0100;

    // R3: zero while reset is held, inputs non-zero
    opA = 16'h1234; opB = 16'h5678;
    repeat (3) @(negedge clk);
    chk("R3 in reset", product, 32'h0);

    // R3/R4: release, first edge does not load, second does
    rstN = 1'b1;
    opA = 16'hA7C0; opB = 16'h1440;
    @(negedge clk);
    chk("R3 first edge after release", product, 32'h0);
    @(negedge clk);
    chk("R4 test vector", product, 32'hF904F000);

    // R2: new inputs do not pass before the edge, output holds when held
    opA = 16'h7FFF; opB = 16'h8000;
    #2;
    chk("R2 no change before edge", product, 32'hF904F000);
    @(negedge clk);
    chk("R2 loaded at edge", product, 32'hC0008000);
    repeat (3) @(negedge clk);
    chk("R2 held output", product, 32'hC0008000);

    // R5: corner pairs, named results
    run("R5 min*min", 16'h8000, 16'h8000);
    chk("R5 min*min value", product, 32'h40000000);
    run("R5 max*max", 16'h7FFF, 16'h7FFF);
    chk("R5 max*max value", product, 32'h3FFF0001);
    run("R5 -1*-1", 16'hFFFF, 16'hFFFF);
    chk("R5 -1*-1 value", product, 32'h00000001);
    run("R5 zero", 16'h0000, 16'h8000);
    chk("R5 zero value", product, 32'h0);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run("R5 corner grid", corners[i], corners[j]);

    // R7: scaling by 1.0
    for (int i = 0; i < 256; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'd257 + 16'd3);
      opA = a; opB = 16'h0100;
      @(negedge clk);
      chk("R7 unit scale", product, {{16{a[15]}}, a} << 8);
    end

    // R1: every upper-byte pair with varied lower bytes
    for (int hA = 0; hA < 256; hA++)
      for (int hB = 0; hB < 256; hB++) begin
        logic [7:0] lA, lB;
        lA = 8'((hA * 37 + hB * 11) & 255);
        lB = 8'(((hA * 5) ^ (hB * 91)) & 255);
        run("R1 sweep", {8'(hA), lA}, {8'(hB), lB});
      end

    // R1/R6: pseudo-random operands
    seed = 32'h1ACE_5EED;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = seed[31:16];
      seed = seed * 32'd1664525 + 32'd1013904223;
      b = seed[31:16];
      run("R1 random", a, b);
      if (a != 16'h0 && b != 16'h0)
        chk("R6 sign", {31'b0, product[31]}, {31'b0, a[15] ^ b[15]});
    end

    prevExp = refMul(16'h0000, 16'h0000);
    run("R1 final zero", 16'h0000, 16'h0000);
    chk("R5 final zero value", product, prevExp);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule